// File: doc/BRIEF.md
# SMBus Response Timeout and Error Reporter

This block watches an SMBus master while a transaction runs. It does not make bits. It takes strobes from the bit engine and decides when the current cycle must be dropped. After the engine has shifted out its final bit, the block waits for the device and counts ticks of a slow reference clock. If nothing ends the wait before the tick limit (800 by default), the block drops the cycle and records a device error.

A negative acknowledge also records a device error, with no wait. A lost arbitration records a bus error. Both error flags are sticky. Software clears each one by writing a one to its bit.

Either flag can raise an interrupt. An enable bit turns the interrupt on, and a select bit sends it either to the ordinary interrupt line or to the system-management interrupt line. Both lines are levels, not pulses.

Top module: `smbTimeoutMon`

## Requirements
- R1: After reset, busErr, devErr, abortCycle, irqOut and smiOut are all 0 and no wait is armed. The remembered SCL level resets to 1, so a high sclLevel just after reset is not a rising edge.
- R2: In idle, a lastBitSent strobe arms the wait with its tick count at zero. A refTick on that same cycle is not counted. While idle, refTick has no effect.
- R3: While waiting with no ending event, the TIMEOUT_TICKS-th refTick (800 by default) sets devErr. On the clock edge that samples that tick, abortCycle goes high and the block returns to idle. One tick fewer leaves devErr at 0.
- R4: While waiting, any of the following ends the wait without an error and clears the count: respValid, ackValid with ackIsNack=0, or a rising edge of sclLevel (1 now, 0 on the previous cycle). An ending event on the same cycle as the final tick wins, and no timeout is raised. Once idle, further ticks do nothing.
- R5: ackValid with ackIsNack=1 sets devErr and raises abortCycle at once, in any state, and ends any wait.
- R6: A collision strobe sets busErr and raises abortCycle in any state, and ends any wait.
- R7: busErr and devErr stay set until cleared through statusClr. Bit 0 clears busErr and bit 1 clears devErr. A zero bit has no effect. A set event on the same cycle as a clear leaves the flag set.
- R8: irqOut = intEn & ~smiSel & (busErr | devErr), and smiOut = intEn & smiSel & (busErr | devErr). When intEn is 0, neither line is high.
- R9: A lastBitSent strobe while already waiting restarts the count from zero, and a tick on that same cycle is not counted.
- R10: abortCycle is high only for the cycle after a clock edge that sampled a timeout, a NACK or a collision. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle pulse per slow reference period |
| lastBitSent | input | 1 | Bit engine has shifted out its final bit and now awaits the device |
| respValid | input | 1 | A valid response edge arrived from the device |
| ackValid | input | 1 | The acknowledge slot was sampled this cycle |
| ackIsNack | input | 1 | With ackValid: 1 = not acknowledged, 0 = acknowledged |
| sclLevel | input | 1 | Current level of the serial clock line |
| collision | input | 1 | The bit engine lost arbitration |
| intEn | input | 1 | Enables interrupt signalling of error flags |
| smiSel | input | 1 | 1 routes the interrupt to smiOut, 0 routes it to irqOut |
| statusClr | input | 2 | Write-one-to-clear pulses: bit 0 busErr, bit 1 devErr |
| abortCycle | output | 1 | One-cycle request to drop the current cycle |
| busErr | output | 1 | Sticky arbitration-loss flag |
| devErr | output | 1 | Sticky device error flag (timeout or NACK) |
| irqOut | output | 1 | Level interrupt on the ordinary line |
| smiOut | output | 1 | Level interrupt on the system-management line |

## Verification
The assertions assume that every strobe input is a clean single-cycle level that is sampled synchronously. They do not assume that strobes are mutually exclusive. The stickiness and routing properties are designed to hold even when a collision, a NACK and a clear all land on the same cycle.

The random stimulus sends every input through the same clock-synchronous drive point, a little after each rising edge. Strobes fire at independent low rates, so overlaps happen but are uncommon. The 800-tick timeout is too long for random stimulus to reach often, so directed sequences cover it.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } waitState_t;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic setBus;
    logic setDev;
    logic abort;
  } ctrlStrobe_t;

endpackage

// File: rtl/smbto_ctrl.sv
module smbto_ctrl
  import smbto_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic        lastBitSent,
  input  logic        respValid,
  input  logic        ackValid,
  input  logic        ackIsNack,
  input  logic        sclLevel,
  input  logic        collision,
  input  logic        cntAtLimit,
  output ctrlStrobe_t strb,
  output logic        waiting
);

  waitState_t state;
  waitState_t nextState;
  logic       sclPrev;
  logic       sclRise;
  logic       nackSeen;
  logic       stopEvent;

  assign sclRise   = sclLevel & ~sclPrev;
  assign nackSeen  = ackValid & ackIsNack;
  assign stopEvent = respValid | (ackValid & ~ackIsNack) | sclRise;
  assign waiting   = (state == ST_WAIT);

  always_comb begin
    strb        = '0;
    nextState   = state;
    strb.setBus = collision;
    strb.setDev = nackSeen;
    if (collision || nackSeen) begin
      nextState     = ST_IDLE;
      strb.cntClear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (lastBitSent) begin
            nextState     = ST_WAIT;
            strb.cntClear = 1'b1;
          end
        end
        ST_WAIT: begin
          if (stopEvent) begin
            nextState     = ST_IDLE;
            strb.cntClear = 1'b1;
          end else if (refTick && cntAtLimit) begin
            strb.setDev   = 1'b1;
            nextState     = ST_IDLE;
            strb.cntClear = 1'b1;
          end else if (lastBitSent) begin
            strb.cntClear = 1'b1;
          end else if (refTick) begin
            strb.cntInc = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
    strb.abort = strb.setBus | strb.setDev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sclPrev <= 1'b1;
    end else begin
      state   <= nextState;
      sclPrev <= sclLevel;
    end
  end

  // An ending event leaves the wait on the next cycle
  AST_STOP_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && (respValid || (ackValid && !ackIsNack))) |=> (state == ST_IDLE)); // R4

  // An armed idle state always enters the wait unless an error preempts it
  AST_ARM_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && lastBitSent && !collision && !nackSeen) |=> (state == ST_WAIT)); // R2

endmodule

// File: rtl/smbto_dp.sv
module smbto_dp
  import smbto_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 800
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic [1:0]  statusClr,
  input  logic        intEn,
  input  logic        smiSel,
  output logic        cntAtLimit,
  output logic        abortCycle,
  output logic        busErr,
  output logic        devErr,
  output logic        irqOut,
  output logic        smiOut
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             anyErr;

  assign cntAtLimit = (tickCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.cntClear) begin
      tickCnt <= '0;
    end else if (strb.cntInc) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // Clear first, then set: a same-cycle event keeps the flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busErr     <= 1'b0;
      devErr     <= 1'b0;
      abortCycle <= 1'b0;
    end else begin
      busErr     <= (busErr & ~statusClr[0]) | strb.setBus;
      devErr     <= (devErr & ~statusClr[1]) | strb.setDev;
      abortCycle <= strb.abort;
    end
  end

  assign anyErr = busErr | devErr;
  assign irqOut = intEn & ~smiSel & anyErr;
  assign smiOut = intEn & smiSel & anyErr;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < CNT_W'(TIMEOUT_TICKS)); // R3

  AST_BUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && !statusClr[0]) |=> busErr); // R7

  AST_DEV_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (devErr && !statusClr[1]) |=> devErr); // R7

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && smiOut)); // R8

endmodule

// File: rtl/smbTimeoutMon.sv
module smbTimeoutMon
  import smbto_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       lastBitSent,
  input  logic       respValid,
  input  logic       ackValid,
  input  logic       ackIsNack,
  input  logic       sclLevel,
  input  logic       collision,
  input  logic       intEn,
  input  logic       smiSel,
  input  logic [1:0] statusClr,
  output logic       abortCycle,
  output logic       busErr,
  output logic       devErr,
  output logic       irqOut,
  output logic       smiOut
);

  ctrlStrobe_t strb;
  logic        cntAtLimit;
  logic        waiting;

  smbto_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refTick    (refTick),
    .lastBitSent(lastBitSent),
    .respValid  (respValid),
    .ackValid   (ackValid),
    .ackIsNack  (ackIsNack),
    .sclLevel   (sclLevel),
    .collision  (collision),
    .cntAtLimit (cntAtLimit),
    .strb       (strb),
    .waiting    (waiting)
  );

  smbto_dp #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .statusClr (statusClr),
    .intEn     (intEn),
    .smiSel    (smiSel),
    .cntAtLimit(cntAtLimit),
    .abortCycle(abortCycle),
    .busErr    (busErr),
    .devErr    (devErr),
    .irqOut    (irqOut),
    .smiOut    (smiOut)
  );

  AST_COLL_BUS: assert property (@(posedge clk) disable iff (!rstN)
    collision |=> (busErr && abortCycle && !waiting)); // R6

  AST_NACK_DEV: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackIsNack) |=> (devErr && abortCycle && !waiting)); // R5

  AST_DEV_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devErr) |-> abortCycle); // R3

  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!collision && !(ackValid && ackIsNack) && !waiting) |=> !abortCycle); // R10

endmodule

// File: tb/tb_smbTimeoutMon.sv
module tb_smbTimeoutMon;

  localparam int LIMIT = 800;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0, lastBitSent = 1'b0, respValid = 1'b0;
  logic       ackValid = 1'b0, ackIsNack = 1'b0, sclLevel = 1'b1;
  logic       collision = 1'b0, intEn = 1'b0, smiSel = 1'b0;
  logic [1:0] statusClr = 2'b00;
  logic       abortCycle, busErr, devErr, irqOut, smiOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  bit mWait, mBus, mDev, mAbort, mPrevScl;
  int mCnt;

  smbTimeoutMon dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .lastBitSent(lastBitSent),
    .respValid(respValid), .ackValid(ackValid), .ackIsNack(ackIsNack),
    .sclLevel(sclLevel), .collision(collision), .intEn(intEn), .smiSel(smiSel),
    .statusClr(statusClr), .abortCycle(abortCycle), .busErr(busErr),
    .devErr(devErr), .irqOut(irqOut), .smiOut(smiOut)
  );

  always #5 clk = ~clk;

  function automatic bit expIrq(bit en, bit sel, bit b, bit d);
    return en & ~sel & (b | d);
  endfunction

  function automatic bit expSmi(bit en, bit sel, bit b, bit d);
    return en & sel & (b | d);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic modelStep();
    bit rise, nack, stopEv;
    rise = sclLevel & ~mPrevScl;
    mPrevScl = sclLevel;
    nack = ackValid & ackIsNack;
    stopEv = respValid | (ackValid & ~ackIsNack) | rise;
    mAbort = 1'b0;
    mBus = mBus & ~statusClr[0];
    mDev = mDev & ~statusClr[1];
    if (collision) begin mBus = 1'b1; mAbort = 1'b1; end
    if (nack) begin mDev = 1'b1; mAbort = 1'b1; end
    if (collision || nack) begin
      mWait = 1'b0; mCnt = 0;
    end else if (mWait) begin
      if (stopEv) begin mWait = 1'b0; mCnt = 0; end
      else if (refTick && mCnt == LIMIT - 1) begin
        mDev = 1'b1; mAbort = 1'b1; mWait = 1'b0; mCnt = 0;
      end
      else if (lastBitSent) mCnt = 0;
      else if (refTick) mCnt++;
    end else if (lastBitSent) begin
      mWait = 1'b1; mCnt = 0;
    end
  endtask

  // One clock: model update, edge, compare, then drop the pulse inputs
  task automatic cyc();
    modelStep();
    @(posedge clk);
    #1;
    chk("R6", "busErr", busErr, mBus);
    chk("R3", "devErr", devErr, mDev);
    chk("R10", "abortCycle", abortCycle, mAbort);
    chk("R8", "irqOut", irqOut, expIrq(intEn, smiSel, mBus, mDev));
    chk("R8", "smiOut", smiOut, expSmi(intEn, smiSel, mBus, mDev));
    refTick = 0; lastBitSent = 0; respValid = 0; ackValid = 0;
    ackIsNack = 0; collision = 0; statusClr = 2'b00;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      refTick = 1'b1;
      cyc();
    end
  endtask

  task automatic clearAll();
    statusClr = 2'b11;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17c3));
    mWait = 0; mBus = 0; mDev = 0; mAbort = 0; mPrevScl = 1; mCnt = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chk("R1", "busErr reset", busErr, 1'b0);
    chk("R1", "devErr reset", devErr, 1'b0);
    chk("R1", "abortCycle reset", abortCycle, 1'b0);
    chk("R1", "irqOut reset", irqOut, 1'b0);
    chk("R1", "smiOut reset", smiOut, 1'b0);
    cyc();
    chk("R1", "no spurious rise", abortCycle, 1'b0);

    // R2: idle ticks ignored
    ticks(LIMIT + 50);
    chk("R2", "idle ticks devErr", devErr, 1'b0);

    // R3: timeout at exactly LIMIT ticks; tick on arming cycle not counted
    sclLevel = 0;
    lastBitSent = 1; refTick = 1; cyc();
    ticks(LIMIT - 1);
    chk("R3", "one tick short", devErr, 1'b0);
    ticks(1);
    chk("R3", "timeout devErr", devErr, 1'b1);
    chk("R3", "timeout abort", abortCycle, 1'b1);
    cyc();
    chk("R10", "abort one cycle", abortCycle, 1'b0);

    // R8 routing combinations with devErr set
    intEn = 0; smiSel = 0; cyc();
    chk("R8", "disabled irq", irqOut, 1'b0);
    chk("R8", "disabled smi", smiOut, 1'b0);
    intEn = 1; smiSel = 0; cyc();
    chk("R8", "irq route", irqOut, 1'b1);
    intEn = 1; smiSel = 1; cyc();
    chk("R8", "smi route", smiOut, 1'b1);
    chk("R8", "smi route irq low", irqOut, 1'b0);

    // R7: clear only devErr; zero bit has no effect
    collision = 1; cyc();
    statusClr = 2'b10; cyc();
    chk("R7", "devErr cleared", devErr, 1'b0);
    chk("R7", "busErr kept", busErr, 1'b1);
    statusClr = 2'b01; collision = 1; cyc();
    chk("R7", "set wins over clear", busErr, 1'b1);
    clearAll();
    chk("R7", "all cleared", busErr | devErr, 1'b0);

    // R4: response ends wait; later ticks ignored
    lastBitSent = 1; cyc();
    ticks(500);
    respValid = 1; cyc();
    ticks(LIMIT + 10);
    chk("R4", "resp stops count", devErr, 1'b0);
    // ACK ends the wait
    lastBitSent = 1; cyc();
    ticks(LIMIT - 1);
    ackValid = 1; ackIsNack = 0; refTick = 1; cyc();
    chk("R4", "ack beats timeout", devErr, 1'b0);
    // SCL rise on the final tick wins
    sclLevel = 0;
    lastBitSent = 1; cyc();
    ticks(LIMIT - 1);
    sclLevel = 1; refTick = 1; cyc();
    chk("R4", "scl rise beats timeout", devErr, 1'b0);
    sclLevel = 0; cyc();

    // R9: restart while waiting
    lastBitSent = 1; cyc();
    ticks(500);
    lastBitSent = 1; refTick = 1; cyc();
    ticks(LIMIT - 1);
    chk("R9", "restart delays timeout", devErr, 1'b0);
    ticks(1);
    chk("R9", "timeout after restart", devErr, 1'b1);
    clearAll();

    // R5: NACK in idle and while waiting
    ackValid = 1; ackIsNack = 1; cyc();
    chk("R5", "nack idle devErr", devErr, 1'b1);
    chk("R5", "nack idle abort", abortCycle, 1'b1);
    clearAll();
    lastBitSent = 1; cyc();
    ticks(100);
    ackValid = 1; ackIsNack = 1; cyc();
    chk("R5", "nack in wait", devErr, 1'b1);
    clearAll();
    ticks(LIMIT);
    chk("R5", "nack ended wait", devErr, 1'b0);

    // R6: collision while waiting
    lastBitSent = 1; cyc();
    ticks(10);
    collision = 1; cyc();
    chk("R6", "collision busErr", busErr, 1'b1);
    chk("R6", "collision abort", abortCycle, 1'b1);
    clearAll();
    ticks(LIMIT);
    chk("R6", "collision ended wait", devErr, 1'b0);

    // Random phase checked against the model
    for (int i = 0; i < 6000; i++) begin
      refTick     = ($urandom % 2) == 0;
      lastBitSent = ($urandom % 40) == 0;
      respValid   = ($urandom % 150) == 0;
      ackValid    = ($urandom % 100) == 0;
      ackIsNack   = ($urandom % 2) == 0;
      collision   = ($urandom % 300) == 0;
      statusClr   = {(($urandom % 30) == 0), (($urandom % 30) == 0)};
      if (($urandom % 50) == 0) sclLevel = ~sclLevel;
      if (($urandom % 100) == 0) intEn = ~intEn;
      if (($urandom % 100) == 0) smiSel = ~smiSel;
      cyc();
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule